// File: doc/BRIEF.md
# Context-Configured Word Datapath Cell

This block is one processing cell of a coarse-grained compute array. Every cycle in which `exec_en` is high, the cell decodes a 32-bit context word that chooses two 16-bit operands, an arithmetic or logic function, an output shift, a destination register and two write strobes. The result lands in a 32-bit output register, and its low half is also written back into a small local register file. Operands can come from the four nearest neighbours, four peer cells in the same row or column group, a pair of data-bus words, an express-lane word, the cell's own registers, a feedback register holding the previous port-A operand, or the low half of the output register.

Arithmetic runs on a 28-bit signed path. 16-bit operands and the 12-bit constant are sign-extended into it, so repeated multiply-accumulate steps keep full precision until they wrap at 28 bits. The 28-bit result is sign-extended to 32 bits and then shifted. A sign flag records the sign of the port-A operand. The cell has no back-pressure. The execute strobe is a plain control pin, and every context presented with it is consumed in that cycle. The outputs are registered and appear one clock edge after the execute cycle.

Top module: `datapath_cell`

## Requirements
- R1: After the asynchronous active-low reset, the output register, sign flag, feedback register, all four registers and both write strobes are zero.
- R2: The context word decodes as follows. Bit 31 is the bus write enable and bit 30 the lane write enable. Bits 29:28 are the destination register and bit 27 the shift direction. Bits 26:23 are the shift amount, bits 22:19 the port-A select and bits 18:16 the port-B select. Bits 15:12 are the opcode and bits 11:0 the signed constant.
- R3: Opcodes 0 pass A, 1 A+B, 2 A-B, 3 AND, 4 OR and 5 XOR act on the operands after sign extension from 16 to 28 bits.
- R4: Opcode 6 produces the absolute difference |A-B| of the signed operands.
- R5: Opcode 7 produces A times the signed 12-bit constant.
- R6: Opcode 8 adds A times the constant to bits 27:0 of the output register, as signed values. The sum wraps at 28 bits.
- R7: The 28-bit result is sign-extended to 32 bits. Direction 0 then shifts it left, filling with zeros. Direction 1 shifts it right arithmetically. The amount is 0 to 15.
- R8: Opcodes 9 to 15 are no-ops. The output register and the register file hold their values.
- R9: For opcodes 0 to 8, bits 15:0 of the shifted result are written to the destination register. The other registers hold their values.
- R10: Port-A select: 0 to 3 pick registers R0 to R3. 4 to 7 pick the north, east, south and west neighbours (`nbr_in[0..3]`). 8 to 11 pick `peer_in[0..3]`. 12 picks `bus_a`, 13 picks `lane_in`, 14 the feedback register and 15 bits 15:0 of the output register.
- R11: Port-B select: 0 to 3 pick R0 to R3. 4 picks `bus_b`. 5, 6 and 7 pick the north, east and south neighbours.
- R12: On every execute cycle, including no-ops, the sign flag takes bit 15 of the port-A operand and the feedback register takes the port-A operand.
- R13: When `exec_en` is low, no state changes and both strobes read 0 in the following cycle.
- R14: `bus_wr` and `lane_wr` are high in the cycle after an execute cycle whose bit 31 or bit 30, respectively, was set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Execute the presented context this cycle |
| ctx_word | input | 32 | Context word |
| nbr_in | input | 4x16 | Neighbour outputs: N, E, S, W |
| peer_in | input | 4x16 | Row/column peer outputs |
| bus_a | input | 16 | Data-bus word for port A |
| bus_b | input | 16 | Data-bus word for port B |
| lane_in | input | 16 | Express-lane word |
| out_reg | output | 32 | Output register |
| sign_flag | output | 1 | Sign of the last port-A operand |
| lane_wr | output | 1 | Express-lane write strobe |
| bus_wr | output | 1 | Data-bus write strobe |

## Verification
The bench crosses every opcode with operand pairs at the 16-bit extremes (0x7FFF, 0x8000, 0xFFFF). A cell that zero-extended operands, or took the constant as unsigned, would then show wrong upper bits or wrong products. A long run of accumulations is driven past the 28-bit range, so an accumulator that saturated or carried into bits 31:28 would diverge from the wrapped, sign-extended value. Every shift amount is swept in both directions on negative inputs, which exposes a logical right shift used where an arithmetic one is required. No-op opcodes and idle cycles are followed by readbacks of the output and of the registers, and these catch a cell that writes back on a no-op.

// File: rtl/cell_ctx_pkg.sv
package cell_ctx_pkg;
  localparam int DATA_W = 16;
  localparam int K_W    = 12;
  localparam int ACC_W  = 28;
  localparam int OUT_W  = 32;
  localparam int NREG   = 4;
  localparam int SEL_A_N = 16;
  localparam int SEL_B_N = 8;

  // Field order is the decode order of the 32-bit context word (MSB first).
  typedef struct packed {
    logic       bus_we;
    logic       lane_we;
    logic [1:0] dst;
    logic       shr;
    logic [3:0] shamt;
    logic [3:0] sel_a;
    logic [2:0] sel_b;
    logic [3:0] op;
    logic [K_W-1:0] k;
  } ctx_t;

  typedef enum logic [3:0] {
    OP_PASS = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_ABSD = 4'd6,
    OP_MULK = 4'd7,
    OP_MAC  = 4'd8
  } alu_op_e;

  function automatic logic op_is_live(input logic [3:0] op);
    return op <= OP_MAC;
  endfunction
endpackage

// File: rtl/cell_opsel.sv
module cell_opsel
  import cell_ctx_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NREG
) (
  input  logic [3:0]             sel_a,
  input  logic [2:0]             sel_b,
  input  logic [NR-1:0][DW-1:0]  rf_q,
  input  logic [3:0][DW-1:0]     nbr,
  input  logic [3:0][DW-1:0]     peer,
  input  logic [DW-1:0]          bus_a,
  input  logic [DW-1:0]          bus_b,
  input  logic [DW-1:0]          lane,
  input  logic [DW-1:0]          fb,
  input  logic [DW-1:0]          out_lo,
  output logic [DW-1:0]          opa,
  output logic [DW-1:0]          opb
);
  logic [SEL_A_N-1:0][DW-1:0] src_a;
  logic [SEL_B_N-1:0][DW-1:0] src_b;

  for (genvar g = 0; g < 4; g++) begin : g_rf_src
    assign src_a[g]     = rf_q[g];
    assign src_b[g]     = rf_q[g];
    assign src_a[4 + g] = nbr[g];
    assign src_a[8 + g] = peer[g];
  end

  assign src_a[12] = bus_a;
  assign src_a[13] = lane;
  assign src_a[14] = fb;
  assign src_a[15] = out_lo;

  assign src_b[4] = bus_b;
  for (genvar g = 0; g < 3; g++) begin : g_nbr_b
    assign src_b[5 + g] = nbr[g];
  end

  assign opa = src_a[sel_a];
  assign opb = src_b[sel_b];
endmodule

// File: rtl/cell_regfile.sv
module cell_regfile
  import cell_ctx_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NR = NREG,
  localparam int AW = $clog2(NR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [DW-1:0]         wdata,
  output logic [NR-1:0][DW-1:0] q
);
  for (genvar g = 0; g < NR; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     q[g] <= '0;
      else if (we && waddr == AW'(g)) q[g] <= wdata;
    end

    // R9
    rf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && waddr == AW'(g)) |=> $stable(q[g]));
    // R9
    rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == AW'(g)) |=> q[g] == $past(wdata));
  end
endmodule

// File: rtl/cell_alu.sv
module cell_alu
  import cell_ctx_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int KW = K_W,
  parameter int AW = ACC_W,
  parameter int OW = OUT_W
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [KW-1:0] k,
  input  logic [AW-1:0] acc_in,
  input  logic          shr,
  input  logic [3:0]    shamt,
  output logic          live,
  output logic [OW-1:0] res
);
  logic signed [AW-1:0] sa, sb, sk, diff, prod, r;
  logic        [OW-1:0] ext;

  assign sa   = {{(AW-DW){a[DW-1]}}, a};
  assign sb   = {{(AW-DW){b[DW-1]}}, b};
  assign sk   = {{(AW-KW){k[KW-1]}}, k};
  assign diff = sa - sb;
  assign prod = sa * sk;
  assign live = op_is_live(op);

  always_comb begin
    case (alu_op_e'(op))
      OP_PASS: r = sa;
      OP_ADD:  r = sa + sb;
      OP_SUB:  r = diff;
      OP_AND:  r = sa & sb;
      OP_OR:   r = sa | sb;
      OP_XOR:  r = sa ^ sb;
      OP_ABSD: r = diff[AW-1] ? -diff : diff;
      OP_MULK: r = prod;
      OP_MAC:  r = $signed(acc_in) + prod;
      default: r = '0;
    endcase
  end

  assign ext = {{(OW-AW){r[AW-1]}}, r};

  always_comb begin
    if (shr) res = $signed(ext) >>> shamt;
    else     res = ext << shamt;
  end
endmodule

// File: rtl/datapath_cell.sv
module datapath_cell
  import cell_ctx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  exec_en,
  input  logic [31:0]           ctx_word,
  input  logic [3:0][15:0]      nbr_in,
  input  logic [3:0][15:0]      peer_in,
  input  logic [15:0]           bus_a,
  input  logic [15:0]           bus_b,
  input  logic [15:0]           lane_in,
  output logic [31:0]           out_reg,
  output logic                  sign_flag,
  output logic                  lane_wr,
  output logic                  bus_wr
);
  ctx_t c;
  assign c = ctx_t'(ctx_word);

  logic [NREG-1:0][DATA_W-1:0] rf_q;
  logic [DATA_W-1:0] opa, opb, fb_q;
  logic [OUT_W-1:0]  res, out_q;
  logic              live;

  cell_opsel u_sel (
    .sel_a(c.sel_a), .sel_b(c.sel_b), .rf_q(rf_q), .nbr(nbr_in), .peer(peer_in),
    .bus_a(bus_a), .bus_b(bus_b), .lane(lane_in), .fb(fb_q),
    .out_lo(out_q[DATA_W-1:0]), .opa(opa), .opb(opb)
  );

  cell_alu u_alu (
    .op(c.op), .a(opa), .b(opb), .k(c.k), .acc_in(out_q[ACC_W-1:0]),
    .shr(c.shr), .shamt(c.shamt), .live(live), .res(res)
  );

  cell_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .we(exec_en && live), .waddr(c.dst),
    .wdata(res[DATA_W-1:0]), .q(rf_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= '0;
      fb_q      <= '0;
      sign_flag <= 1'b0;
      bus_wr    <= 1'b0;
      lane_wr   <= 1'b0;
    end else begin
      bus_wr  <= exec_en && c.bus_we;
      lane_wr <= exec_en && c.lane_we;
      if (exec_en) begin
        fb_q      <= opa;
        sign_flag <= opa[DATA_W-1];
        if (live) out_q <= res;
      end
    end
  end

  assign out_reg = out_q;

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(out_q) && $stable(sign_flag) && $stable(fb_q) && !bus_wr && !lane_wr);
  // R8
  noop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && c.op > 4'd8) |=> $stable(out_q));
  // R7
  sext_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && c.op <= 4'd8 && c.shamt == 4'd0) |=> (out_q[31:27] == 5'h00 || out_q[31:27] == 5'h1f));
  // R12
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |=> sign_flag == $past(opa[DATA_W-1]));
  // R14
  bus_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && ctx_word[31]) |=> bus_wr);
  // R14
  lane_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_en && ctx_word[30]) |=> !lane_wr);
endmodule

// File: tb/tb_datapath_cell.sv
module tb_datapath_cell;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, exec_en = 1'b0;
  logic [31:0] ctx_word = '0;
  logic [3:0][15:0] nbr_in = '0, peer_in = '0;
  logic [15:0] bus_a = '0, bus_b = '0, lane_in = '0;
  logic [31:0] out_reg;
  logic sign_flag, lane_wr, bus_wr;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] mo = '0;
  logic [15:0] mreg [4];
  logic [15:0] mfb = '0;
  logic mflag = 1'b0, mbus = 1'b0, mlane = 1'b0;

  datapath_cell dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic bw, input logic lw, input logic [1:0] dst,
      input logic shr, input logic [3:0] amt, input logic [3:0] sa, input logic [2:0] sb,
      input logic [3:0] op, input logic [11:0] k);
    return {bw, lw, dst, shr, amt, sa, sb, op, k};
  endfunction

  function automatic logic [15:0] src_a(input logic [3:0] s);
    if (s < 4'd4)  return mreg[s[1:0]];
    if (s < 4'd8)  return nbr_in[s[1:0]];
    if (s < 4'd12) return peer_in[s[1:0]];
    case (s)
      4'd12:   return bus_a;
      4'd13:   return lane_in;
      4'd14:   return mfb;
      default: return mo[15:0];
    endcase
  endfunction

  function automatic logic [15:0] src_b(input logic [2:0] s);
    if (s < 3'd4) return mreg[s[1:0]];
    if (s == 3'd4) return bus_b;
    return nbr_in[s[1:0] - 2'd1];
  endfunction

  function automatic logic [31:0] model(input logic [3:0] op, input logic [15:0] a,
      input logic [15:0] b, input logic [11:0] k, input logic [31:0] prev,
      input logic shr, input logic [3:0] amt);
    int ai, bi, ki, pi, r;
    logic [27:0] t;
    logic [31:0] e;
    ai = int'($signed(a)); bi = int'($signed(b)); ki = int'($signed(k));
    pi = int'($signed(prev[27:0]));
    case (op)
      4'd0: r = ai;
      4'd1: r = ai + bi;
      4'd2: r = ai - bi;
      4'd3: r = ai & bi;
      4'd4: r = ai | bi;
      4'd5: r = ai ^ bi;
      4'd6: r = (ai > bi) ? ai - bi : bi - ai;
      4'd7: r = ai * ki;
      4'd8: r = pi + ai * ki;
      default: r = 0;
    endcase
    t = r[27:0];
    e = {{4{t[27]}}, t};
    if (shr) e = $signed(e) >>> amt;
    else     e = e << amt;
    return e;
  endfunction

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic run(input logic [31:0] ctx, input string req);
    logic [15:0] a, b;
    logic [31:0] e;
    a = src_a(ctx[22:19]);
    b = src_b(ctx[18:16]);
    e = model(ctx[15:12], a, b, ctx[11:0], mo, ctx[27], ctx[26:23]);
    ctx_word = ctx; exec_en = 1'b1;
    @(posedge clk); @(negedge clk);
    if (ctx[15:12] <= 4'd8) begin
      mo = e;
      mreg[ctx[29:28]] = e[15:0];
    end
    mfb = a; mflag = a[15]; mbus = ctx[31]; mlane = ctx[30];
    chk(req, out_reg, mo);
    chk("R12 flag", {31'b0, sign_flag}, {31'b0, mflag});
    chk("R14 bus", {31'b0, bus_wr}, {31'b0, mbus});
    chk("R14 lane", {31'b0, lane_wr}, {31'b0, mlane});
  endtask

  task automatic idle(input logic [31:0] junk);
    ctx_word = junk; exec_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R13 out", out_reg, mo);
    chk("R13 flag", {31'b0, sign_flag}, {31'b0, mflag});
    chk("R13 strobes", {30'b0, bus_wr, lane_wr}, 32'd0);
  endtask

  logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                            16'h8000, 16'h1234, 16'hFEDC, 16'h00FF};

  initial begin
    fork
      begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
          failures++;
          $display("FAIL watchdog act=timeout exp=finish");
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none
  end

  initial begin
    for (int i = 0; i < 4; i++) mreg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out", out_reg, 32'd0);
    chk("R1 flag/strobes", {29'b0, sign_flag, bus_wr, lane_wr}, 32'd0);
    for (int r = 0; r < 4; r++)
      run(mk(0, 0, 2'(r), 0, 4'd0, 4'(r), 3'd0, 4'd0, 12'd0), "R1 reg readback");

    // R2 R3 R4 R5 R6 R8 R9: opcode x operand sweep from the bus
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          bus_a = vals[i]; bus_b = vals[j];
          run(mk(0, 0, 2'(i + j), 0, 4'd0, 4'd12, 3'd4, 4'(op),
                 12'((i * 341 + j * 935 + op * 77) & 12'hfff)), "R3-class op sweep");
        end

    // R6 long accumulation past the 28-bit range
    run(mk(0, 0, 2'd0, 0, 4'd0, 4'd12, 3'd4, 4'd0, 12'd0), "R6 clear");
    for (int n = 0; n < 40; n++) begin
      bus_a = 16'h7FFF;
      run(mk(0, 0, 2'd1, 0, 4'd0, 4'd12, 3'd4, 4'd8, 12'h7FF), "R6 mac wrap");
    end

    // R7 shift sweep on positive and negative values
    for (int d = 0; d < 2; d++)
      for (int amt = 0; amt < 16; amt++)
        for (int i = 0; i < 8; i++) begin
          bus_a = vals[i];
          run(mk(0, 0, 2'd3, 1'(d), 4'(amt), 4'd12, 3'd4, 4'd0, 12'd0), "R7 shift");
        end

    // R10 port-A sources
    for (int g = 0; g < 4; g++) begin
      nbr_in[g] = 16'hA100 + 16'(g);
      peer_in[g] = 16'h8B00 + 16'(g);
    end
    lane_in = 16'h5C5C;
    for (int s = 4; s < 16; s++) begin
      bus_a = 16'h4D00 + 16'(s);
      run(mk(0, 0, 2'd0, 0, 4'd0, 4'(s), 3'd4, 4'd0, 12'd0), "R10 sel_a");
    end
    bus_a = 16'h9999;
    run(mk(0, 0, 2'd0, 0, 4'd0, 4'd12, 3'd4, 4'd0, 12'd0), "R12 load fb");
    run(mk(0, 0, 2'd1, 0, 4'd0, 4'd14, 3'd4, 4'd0, 12'd0), "R12 feedback reuse");

    // R11 port-B sources through A+B with A = 0 from the bus
    for (int r = 0; r < 4; r++) begin
      bus_a = 16'h1111 * 16'(r + 1);
      run(mk(0, 0, 2'(r), 0, 4'd0, 4'd12, 3'd4, 4'd0, 12'd0), "R9 preload");
    end
    for (int s = 0; s < 8; s++) begin
      bus_a = 16'h0000; bus_b = 16'hC0DE;
      run(mk(0, 0, 2'd3, 0, 4'd0, 4'd12, 3'(s), 4'd1, 12'd0), "R11 sel_b");
    end

    // R8 no-op leaves registers intact: no-op aimed at R2, then read R2
    bus_a = 16'h7777;
    run(mk(0, 0, 2'd2, 0, 4'd0, 4'd12, 3'd4, 4'd0, 12'd0), "R9 load R2");
    bus_a = 16'h0123;
    run(mk(0, 0, 2'd2, 0, 4'd0, 4'd12, 3'd4, 4'd11, 12'd0), "R8 noop");
    run(mk(0, 0, 2'd0, 0, 4'd0, 4'd2, 3'd4, 4'd0, 12'd0), "R8 readback R2");

    // R14 strobes in all combinations, R13 idle cycles
    for (int m = 0; m < 4; m++) begin
      bus_a = 16'(m);
      run(mk(1'(m >> 1), 1'(m), 2'd0, 0, 4'd0, 4'd12, 3'd4, 4'd0, 12'd0), "R14 strobes");
      idle(32'hFFFF_F1FF);
    end
    run(mk(0, 0, 2'd1, 0, 4'd0, 4'd1, 3'd4, 4'd0, 12'd0), "R13 reg after idle");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule